// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

After supply power-up, this block sets the timing for the soft-start of a switching power controller. A synchronous power-good input goes high once the supply has crossed its turn-on level. On the rising edge of that input, the sequencer starts one timed run. First it turns on a precharge current source for a short fixed window, which lifts the feedback node quickly. It then turns on a sink whose strength is set by a multi-bit code sent to an external DAC. The code drops by one at a fixed interval, so the feedback node climbs in steps. At an absolute timeout, measured from the start, the sequencer turns the sink off, drives the code to zero and raises a done flag.

All durations are set in microseconds and converted to clock cycles from the `CLK_HZ` parameter. The precharge window defaults to 12 µs, the step interval to 3000 µs and the total to 24000 µs. The code is 4 bits wide and starts at 8.

The control state machine has four states. In `SS_IDLE` all outputs are low and the block waits. On a power-good rise it moves `SS_IDLE -> SS_PRECHARGE`, where source, sink and code are all active. When the precharge window expires it moves `SS_PRECHARGE -> SS_STAIR`, where the sink steps down. At the total timeout it moves `SS_STAIR -> SS_DONE`. From any state, a low power-good sends it back to `SS_IDLE`.

Top module: `soft_start_seq`

## Requirements
- R1: While `rst_n` is low, `src_en`, `sink_en` and `done` are 0 and `sink_code` is 0, whatever `power_good` does.
- R2: When `power_good` is sampled high at a clock edge after it was sampled low (or after reset), that edge is the start edge. Right after it, `src_en` = 1, `sink_en` = 1 and `sink_code` = 8.
- R3: `src_en` stays high for exactly PRE cycles (12 µs × CLK_HZ / 10^6) after the start edge, and then goes low for the rest of the run.
- R4: Let k be the number of edges since the start edge, with 0 ≤ k < TOTAL. Then `sink_code` equals 8 − floor(k / STEP), where STEP is 3000 µs in cycles. So the code drops by exactly one at each STEP boundary.
- R5: At k = TOTAL (24000 µs in cycles), `sink_en` goes low and `sink_code` goes to 0, and `done` rises in that same cycle.
- R6: After it rises, `done` stays high, with `sink_en`, `src_en` and `sink_code` at 0, for as long as `power_good` stays high.
- R7: At any clock edge where `power_good` is sampled low, all outputs are 0 from that edge on.
- R8: Holding `power_good` high never starts a new run. A new run needs a fresh low-to-high transition, and it then repeats R2 to R5 from the beginning.
- R9: `src_en` is never high unless `sink_en` is high, and `done` is never high together with `sink_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_good | input | 1 | Synchronous supply-above-threshold indication |
| src_en | output | 1 | Precharge current source enable |
| sink_en | output | 1 | Sink current enable |
| sink_code | output | CODE_W | Sink level code for the external DAC |
| done | output | 1 | Soft-start complete |

## Verification
The bench keeps its own count of edges since the last power-good rise and compares all four outputs with that count on every cycle. Full runs with power-good held high past the timeout show the staircase values, the end-of-run handover and the absence of any restart. Directed drops of power-good are placed inside the precharge window, exactly on a step boundary and as a one-cycle pulse. These show that an abort clears everything, and that a short or late pulse still yields a fresh start. Randomly timed high and low intervals then mix aborts at arbitrary points in the sequence with restarts.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        SS_IDLE      = 2'd0,
        SS_PRECHARGE = 2'd1,
        SS_STAIR     = 2'd2,
        SS_DONE      = 2'd3
    } ss_state_t;

    function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned dur_us);
        longint unsigned prod;
        prod = (clk_hz * dur_us) / 64'd1_000_000;
        return 32'(prod);
    endfunction

endpackage

// File: rtl/ss_interval_timer.sv
module ss_interval_timer #(
    parameter int unsigned LIMIT = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    generate
        if (LIMIT <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counted
            localparam logic [W-1:0] LAST = W'(LIMIT - 1);
            logic [W-1:0] phase;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase <= '0;
                end else if (!run) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            assign tick = run && (phase == LAST);

            AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                phase <= LAST) else $error("phase out of range"); // R4
            AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(run) |-> phase == '0) else $error("phase not cleared"); // R4
        end
    endgenerate
endmodule

// File: rtl/ss_elapsed_counter.sv
module ss_elapsed_counter #(
    parameter int unsigned PRE_CYC   = 12,
    parameter int unsigned TOTAL_CYC = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pre_end,
    output logic total_end
);
    localparam int unsigned W = $clog2(TOTAL_CYC + 1);
    localparam logic [W-1:0] PRE_LAST   = W'(PRE_CYC - 1);
    localparam logic [W-1:0] TOTAL_LAST = W'(TOTAL_CYC - 1);

    logic [W-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (!run) begin
            elapsed <= '0;
        end else if (elapsed != TOTAL_LAST) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign pre_end   = run && (elapsed == PRE_LAST);
    assign total_end = run && (elapsed == TOTAL_LAST);

    AST_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= TOTAL_LAST) else $error("elapsed beyond total"); // R5
    AST_ELAPSED_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && $past(elapsed) != TOTAL_LAST) |-> elapsed == $past(elapsed) + 1'b1)
        else $error("elapsed skipped"); // R3
endmodule

// File: rtl/ss_level_counter.sv
module ss_level_counter #(
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned INIT_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              hold,
    input  logic              step,
    output logic [CODE_W-1:0] level
);
    localparam logic [CODE_W-1:0] INIT = CODE_W'(INIT_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (load) begin
            level <= INIT;
        end else if (!hold) begin
            level <= '0;
        end else if (step && level != '0) begin
            level <= level - 1'b1;
        end
    end

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= INIT) else $error("level above start value"); // R4
    AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> level == INIT) else $error("load missed"); // R2
endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
    import ss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic power_good,
    input  logic pre_end,
    input  logic total_end,
    output logic start,
    output logic run,
    output logic src_on,
    output logic sink_on,
    output logic fin
);
    ss_state_t state, state_nx;
    logic      pg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SS_IDLE;
            pg_q  <= 1'b0;
        end else begin
            state <= state_nx;
            pg_q  <= power_good;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SS_IDLE: begin
                if (power_good && !pg_q) state_nx = SS_PRECHARGE;
            end
            SS_PRECHARGE: begin
                if (!power_good)  state_nx = SS_IDLE;
                else if (pre_end) state_nx = SS_STAIR;
            end
            SS_STAIR: begin
                if (!power_good)    state_nx = SS_IDLE;
                else if (total_end) state_nx = SS_DONE;
            end
            SS_DONE: begin
                if (!power_good) state_nx = SS_IDLE;
            end
            default: state_nx = SS_IDLE;
        endcase
    end

    always_comb begin
        start   = 1'b0;
        run     = 1'b0;
        src_on  = 1'b0;
        sink_on = 1'b0;
        fin     = 1'b0;
        unique case (state)
            SS_IDLE: begin
                start = power_good && !pg_q;
            end
            SS_PRECHARGE: begin
                run     = 1'b1;
                src_on  = 1'b1;
                sink_on = 1'b1;
            end
            SS_STAIR: begin
                run     = 1'b1;
                sink_on = 1'b1;
            end
            SS_DONE: begin
                fin = 1'b1;
            end
            default: ;
        endcase
    end

    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_PRECHARGE && $past(state) != SS_PRECHARGE) |-> ($past(power_good) && !$past(pg_q)))
        else $error("start without rising edge"); // R8
    AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> state == SS_IDLE) else $error("power loss not honoured"); // R7
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned PRE_US    = 12,
    parameter int unsigned STEP_US   = 3000,
    parameter int unsigned TOTAL_US  = 24000,
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned INIT_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_good,
    output logic              src_en,
    output logic              sink_en,
    output logic [CODE_W-1:0] sink_code,
    output logic              done
);
    import ss_pkg::*;

    localparam int unsigned PRE_CYC   = us_to_cycles(64'(CLK_HZ), 64'(PRE_US));
    localparam int unsigned STEP_CYC  = us_to_cycles(64'(CLK_HZ), 64'(STEP_US));
    localparam int unsigned TOTAL_CYC = us_to_cycles(64'(CLK_HZ), 64'(TOTAL_US));

    logic start, run, src_on, sink_on, fin;
    logic pre_end, total_end, step_tick;
    logic [CODE_W-1:0] level;

    ss_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_good (power_good),
        .pre_end    (pre_end),
        .total_end  (total_end),
        .start      (start),
        .run        (run),
        .src_on     (src_on),
        .sink_on    (sink_on),
        .fin        (fin)
    );

    ss_elapsed_counter #(
        .PRE_CYC   (PRE_CYC),
        .TOTAL_CYC (TOTAL_CYC)
    ) u_elapsed (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pre_end   (pre_end),
        .total_end (total_end)
    );

    ss_interval_timer #(
        .LIMIT (STEP_CYC)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (step_tick)
    );

    ss_level_counter #(
        .CODE_W    (CODE_W),
        .INIT_CODE (INIT_CODE)
    ) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .hold  (run),
        .step  (step_tick),
        .level (level)
    );

    assign src_en    = src_on;
    assign sink_en   = sink_on;
    assign sink_code = sink_on ? level : '0;
    assign done      = fin;

    AST_SRC_WITH_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        src_en |-> sink_en) else $error("source without sink"); // R9
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sink_en && !src_en && sink_code == '0)) else $error("done overlaps sink"); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && power_good) |=> done) else $error("done dropped"); // R6
    AST_PG_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> (!src_en && !sink_en && !done && sink_code == '0)) else $error("outputs after loss"); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sink_en) && sink_en) |-> (sink_code == $past(sink_code) || sink_code == $past(sink_code) - 1'b1))
        else $error("code jumped"); // R4
    AST_START_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en) |-> sink_code == CODE_W'(INIT_CODE)) else $error("bad start code"); // R2
endmodule

// File: tb/soft_start_seq_test.sv
module soft_start_seq_test;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int PRE   = 12;      // 12 us at 1 MHz
    localparam int STEP  = 3000;    // 3000 us at 1 MHz
    localparam int TOTAL = 24000;   // 24000 us at 1 MHz
    localparam int START_CODE = 8;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg = 1'b0;
    logic       src_en, sink_en, done;
    logic [3:0] sink_code;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    bit active = 1'b0;
    bit pg_prev = 1'b0;
    int k = 0;

    always #4 clk = ~clk;

    soft_start_seq #(.CLK_HZ(CLK_HZ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_good (pg),
        .src_en     (src_en),
        .sink_en    (sink_en),
        .sink_code  (sink_code),
        .done       (done)
    );

    // Reference model: edges since the last power-good rise
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            pg_prev <= 1'b0;
            k       <= 0;
        end else begin
            pg_prev <= pg;
            if (!pg) begin
                active <= 1'b0;
                k      <= 0;
            end else if (!pg_prev) begin
                active <= 1'b1;
                k      <= 0;
            end else if (active && k <= TOTAL) begin
                k <= k + 1;
            end
        end
    end

    function automatic int exp_src(input bit a, input int kk);
        return (a && kk < PRE) ? 1 : 0;
    endfunction
    function automatic int exp_sink(input bit a, input int kk);
        return (a && kk < TOTAL) ? 1 : 0;
    endfunction
    function automatic int exp_done(input bit a, input int kk);
        return (a && kk >= TOTAL) ? 1 : 0;
    endfunction
    function automatic int exp_code(input bit a, input int kk);
        if (!a || kk >= TOTAL) return 0;
        return START_CODE - kk / STEP;
    endfunction

    task automatic chk(input string rq, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d, k=%0d)", rq, act, expv, cyc, k);
        end
    endtask

    task automatic check_all();
        string t_src, t_code, t_end;
        if (!rst_n) begin
            t_src = "R1"; t_code = "R1"; t_end = "R1";
        end else if (!active) begin
            t_src = "R7"; t_code = "R7"; t_end = "R7";
        end else begin
            t_src  = (k == 0) ? "R2" : "R3";
            t_code = (k == 0) ? "R2" : "R4";
            t_end  = (k < TOTAL) ? "R4" : ((k == TOTAL) ? "R5" : "R6/R8");
        end
        chk(t_src,  int'(src_en),    exp_src(active, k));
        chk(t_code, int'(sink_code), exp_code(active, k));
        chk(t_end,  int'(sink_en),   exp_sink(active, k));
        chk(t_end,  int'(done),      exp_done(active, k));
        // R9: source only with sink, done never with sink
        chk("R9", int'(src_en && !sink_en), 0);
        chk("R9", int'(done && sink_en), 0);
    endtask

    task automatic run_cycles(input int n, input logic val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            pg = val;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with power_good toggling
        pg = 1'b1;
        run_cycles(3, 1'b0);
        run_cycles(3, 1'b1);
        @(negedge clk);
        pg = 1'b0;
        rst_n = 1'b1;
        run_cycles(4, 1'b0);

        // R2..R6, R8: full run, then hold high well past the end
        run_cycles(1, 1'b1);
        run_cycles(TOTAL + 300, 1'b1);
        run_cycles(3, 1'b0);                 // R7

        // R7: drop during precharge
        run_cycles(6, 1'b1);
        run_cycles(2, 1'b0);

        // R4/R7: drop right at a step boundary
        run_cycles(STEP + 1, 1'b1);
        run_cycles(2, 1'b0);

        // R8: one-cycle pulse, then a fresh full run
        run_cycles(1, 1'b1);
        run_cycles(1, 1'b0);
        run_cycles(TOTAL + 50, 1'b1);
        run_cycles(2, 1'b0);

        // random intervals
        for (int it = 0; it < 12; it++) begin
            int hi_len, lo_len;
            hi_len = $urandom_range(1, 8000);
            lo_len = $urandom_range(1, 4);
            run_cycles(hi_len, 1'b1);
            run_cycles(lo_len, 1'b0);
        end

        // mid-run reset (R1)
        run_cycles(500, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        run_cycles(3, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        run_cycles(20, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule